// File: doc/BRIEF.md
# Audio Root and Bit Clock Enable Generator

This block turns one fast source clock into three timing strobes for a serial audio port. It produces a root-clock enable, a bit-clock enable and a frame (left/right) clock level. An optional prescaler divides the source first. The root-clock enables are then grouped so that each frame holds a selected number of root ticks. Each frame is then split into a selected number of bit slots. The frame clock is low for the first half of every frame and high for the second half.

Software supplies a root-ratio code and a bit-ratio code. Each code comes with a flag that says whether it is a real constraint. If a flag is clear, the block picks a default from the sample length. The block checks the resolved pair: a combination it cannot build sets an error flag and keeps all strobes silent. The configuration is captured only while the port is idle (`run_i` low). When the block is a slave to an external clock master, it drives nothing and ignores the ratio settings.

Top module: `audio_clkgen`

## Requirements
- R1: The root-ratio code selects root ticks per frame: 0 gives 256, 1 gives 512, 2 gives 384, 3 gives 768. Consecutive bit-clock enables are (root ratio / bit ratio) × P source cycles apart. P is defined in R4 and R5.
- R2: The bit-ratio code selects bit-clock enables per frame: 0 gives 32, 1 gives 48, 2 gives 16, 3 gives 24. Exactly that many bit enables fall between two rising edges of `lrclk_o`.
- R3: `lrclk_o` starts low when the port starts running. It first rises after half a frame, and it toggles every half frame. A half frame is (root ratio / 2) × P source cycles.
- R4: With `pre_en_i` high, root-clock enables are `pre_div_i`+1 source cycles apart (P = `pre_div_i`+1).
- R5: With `pre_en_i` low, the root-clock enable is high on every source cycle while running (P = 1).
- R6: With `bfs_set_i` low, the bit ratio defaults to twice the sample length. The sample-length code is 0 for 16 bits, 1 for 8 bits and 2 for 24 bits.
- R7: With `rfs_set_i` low, the root ratio defaults to 256 when the bit ratio is 16 or 32, and to 384 otherwise.
- R8: A 24-bit sample length with a resolved root ratio of 256 or 512 sets `cfg_err_o`, and no strobe is produced.
- R9: A root ratio that is not a whole multiple of the bit ratio sets `cfg_err_o`, and so does sample-length code 3. No strobe is produced in either case.
- R10: With `slave_i` high, all three clock outputs stay low and `cfg_err_o` stays low, whatever the ratio inputs are.
- R11: The configuration inputs are captured only while `run_i` is low. Changes made while `run_i` is high have no effect until the next idle period. While `run_i` is low, no strobe is produced.
- R12: A bit-clock enable only occurs on a cycle that also carries a root-clock enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast source clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slave_i | input | 1 | High when an external master owns the audio clocks |
| run_i | input | 1 | High while the port is streaming; low means idle |
| pre_en_i | input | 1 | Prescaler enable |
| pre_div_i | input | PRE_W | Prescaler division minus one |
| rfs_code_i | input | 2 | Root-ratio code |
| rfs_set_i | input | 1 | Root-ratio code is a constraint |
| bfs_code_i | input | 2 | Bit-ratio code |
| bfs_set_i | input | 1 | Bit-ratio code is a constraint |
| smp_len_i | input | 2 | Sample-length code |
| rclk_en_o | output | 1 | Root-clock enable strobe |
| bclk_en_o | output | 1 | Bit-clock enable strobe |
| lrclk_o | output | 1 | Frame clock level |
| cfg_err_o | output | 1 | Resolved configuration cannot be built |

## Verification
The ratio codes do not map to their values in increasing order. A design that decodes them as increasing values would show wrong bit spacing or a wrong bit count per frame. The bench therefore sweeps every code, both with and without constraints.

The 24-bit rule, the non-integer ratio pairs and the reserved sample length must raise the error flag and silence the strobes. A design that missed one of these would emit clocks with a broken frame.

Every running case also rewrites the ratio inputs right after `run_i` rises. A design that reloads its settings mid-stream would show changed spacing. Slave mode and idle windows are checked for total silence.

// File: rtl/acg_pkg.sv
package acg_pkg;

  localparam int unsigned RW = 6;

  typedef enum logic [1:0] {
    SL_16  = 2'd0,
    SL_8   = 2'd1,
    SL_24  = 2'd2,
    SL_RSV = 2'd3
  } smp_len_e;

  typedef struct packed {
    logic          pre_en;
    logic          err;
    logic [RW-1:0] rpb;
    logic [RW-1:0] half;
  } ratio_cfg_t;

  // bit code 0:32 1:48 2:16 3:24 ; two bits per sample by default
  function automatic logic [1:0] dflt_bit_code(smp_len_e l);
    case (l)
      SL_8:    return 2'd2;
      SL_24:   return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  // root code 0:256 2:384
  function automatic logic [1:0] dflt_root_code(logic [1:0] b);
    return (b == 2'd0 || b == 2'd2) ? 2'd0 : 2'd2;
  endfunction

  // root ticks per bit slot; zero marks a non-integer pairing
  function automatic logic [RW-1:0] root_per_bit(logic [1:0] r, logic [1:0] b);
    case ({r, b})
      4'h0: return 6'd8;   4'h1: return 6'd0;  4'h2: return 6'd16; 4'h3: return 6'd0;
      4'h4: return 6'd16;  4'h5: return 6'd0;  4'h6: return 6'd32; 4'h7: return 6'd0;
      4'h8: return 6'd12;  4'h9: return 6'd8;  4'hA: return 6'd24; 4'hB: return 6'd16;
      4'hC: return 6'd24;  4'hD: return 6'd16; 4'hE: return 6'd48; default: return 6'd32;
    endcase
  endfunction

  function automatic logic [RW-1:0] half_bits(logic [1:0] b);
    case (b)
      2'd0:    return 6'd16;
      2'd1:    return 6'd24;
      2'd2:    return 6'd8;
      default: return 6'd12;
    endcase
  endfunction

endpackage

// File: rtl/acg_cfg.sv
module acg_cfg
  import acg_pkg::*;
#(
  parameter int unsigned PRE_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             pre_en_i,
  input  logic [PRE_W-1:0] pre_div_i,
  input  logic [1:0]       rfs_code_i,
  input  logic             rfs_set_i,
  input  logic [1:0]       bfs_code_i,
  input  logic             bfs_set_i,
  input  logic [1:0]       smp_len_i,
  output ratio_cfg_t       cfg_o,
  output logic [PRE_W-1:0] div_o
);

  smp_len_e         len;
  logic [1:0]       bcode, rcode;
  ratio_cfg_t       cfg_d, cfg_q;
  logic [PRE_W-1:0] div_d, div_q;

  always_comb begin
    len    = smp_len_e'(smp_len_i);
    bcode  = bfs_set_i ? bfs_code_i : dflt_bit_code(len);
    rcode  = rfs_set_i ? rfs_code_i : dflt_root_code(bcode);
    cfg_d  = cfg_q;
    div_d  = div_q;
    if (load_i) begin
      cfg_d.pre_en = pre_en_i;
      cfg_d.rpb    = root_per_bit(rcode, bcode);
      cfg_d.half   = half_bits(bcode);
      cfg_d.err    = (len == SL_RSV)
                   || (len == SL_24 && !rcode[1])
                   || (root_per_bit(rcode, bcode) == '0);
      div_d        = pre_div_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      div_q <= '0;
    end else begin
      cfg_q <= cfg_d;
      div_q <= div_d;
    end
  end

  assign cfg_o = cfg_q;
  assign div_o = div_q;

endmodule

// File: rtl/acg_prescaler.sv
module acg_prescaler #(
  parameter int unsigned PRE_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             pre_en_i,
  input  logic [PRE_W-1:0] pre_div_i,
  output logic             tick_o
);

  logic [PRE_W-1:0] cnt_d, cnt_q;
  logic             tick;

  always_comb begin
    tick  = active_i && (!pre_en_i || cnt_q == pre_div_i);
    cnt_d = cnt_q;
    if (!active_i || tick) cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign tick_o = tick;

endmodule

// File: rtl/acg_divider.sv
module acg_divider #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         active_i,
  input  logic         tick_i,
  input  logic [W-1:0] rpb_i,
  input  logic [W-1:0] half_i,
  output logic         bclk_en_o,
  output logic         lr_o
);

  logic [W-1:0] rcnt_d, rcnt_q, bcnt_d, bcnt_q;
  logic         lr_d, lr_q;
  logic         bit_tick, half_end;

  always_comb begin
    bit_tick = tick_i && (rcnt_q == rpb_i - 1'b1);
    half_end = bit_tick && (bcnt_q == half_i - 1'b1);
    rcnt_d   = rcnt_q;
    bcnt_d   = bcnt_q;
    lr_d     = lr_q;
    if (!active_i) begin
      rcnt_d = '0;
      bcnt_d = '0;
      lr_d   = 1'b0;
    end else begin
      if (tick_i)   rcnt_d = bit_tick ? '0 : rcnt_q + 1'b1;
      if (bit_tick) bcnt_d = half_end ? '0 : bcnt_q + 1'b1;
      if (half_end) lr_d   = ~lr_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rcnt_q <= '0;
      bcnt_q <= '0;
      lr_q   <= 1'b0;
    end else begin
      rcnt_q <= rcnt_d;
      bcnt_q <= bcnt_d;
      lr_q   <= lr_d;
    end
  end

  assign bclk_en_o = bit_tick;
  assign lr_o      = lr_q;

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import acg_pkg::*;
#(
  parameter int unsigned PRE_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slave_i,
  input  logic             run_i,
  input  logic             pre_en_i,
  input  logic [PRE_W-1:0] pre_div_i,
  input  logic [1:0]       rfs_code_i,
  input  logic             rfs_set_i,
  input  logic [1:0]       bfs_code_i,
  input  logic             bfs_set_i,
  input  logic [1:0]       smp_len_i,
  output logic             rclk_en_o,
  output logic             bclk_en_o,
  output logic             lrclk_o,
  output logic             cfg_err_o
);

  ratio_cfg_t       cfg;
  logic [PRE_W-1:0] div;
  logic             active, tick, bit_tick, lr;

  acg_cfg #(.PRE_W(PRE_W)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(!run_i),
    .pre_en_i(pre_en_i), .pre_div_i(pre_div_i),
    .rfs_code_i(rfs_code_i), .rfs_set_i(rfs_set_i),
    .bfs_code_i(bfs_code_i), .bfs_set_i(bfs_set_i),
    .smp_len_i(smp_len_i), .cfg_o(cfg), .div_o(div)
  );

  assign active = run_i && !slave_i && !cfg.err;

  acg_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_i(active),
    .pre_en_i(cfg.pre_en), .pre_div_i(div), .tick_o(tick)
  );

  acg_divider #(.W(RW)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_i(active), .tick_i(tick),
    .rpb_i(cfg.rpb), .half_i(cfg.half), .bclk_en_o(bit_tick), .lr_o(lr)
  );

  assign rclk_en_o = tick;
  assign bclk_en_o = bit_tick;
  assign lrclk_o   = lr && active;
  assign cfg_err_o = cfg.err && !slave_i;

endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       slave_i,
  input logic       run_i,
  input logic [1:0] rfs_code_i,
  input logic       rfs_set_i,
  input logic [1:0] smp_len_i,
  input logic       rclk_en_o,
  input logic       bclk_en_o,
  input logic       lrclk_o,
  input logic       cfg_err_o
);

  p_slave_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slave_i |-> (!rclk_en_o && !bclk_en_o && !lrclk_o && !cfg_err_o));

  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (!rclk_en_o && !bclk_en_o && !lrclk_o));

  p_bit_on_root_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bclk_en_o |-> rclk_en_o);

  p_err_held_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && !slave_i && !$past(slave_i)) |-> $stable(cfg_err_o));

  p_err_silent_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (!rclk_en_o && !bclk_en_o && !lrclk_o));

  p_lr_after_bit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && !slave_i && !$past(slave_i)
     && lrclk_o != $past(lrclk_o)) |-> $past(bclk_en_o));

  p_wide_root_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !slave_i && smp_len_i == 2'd2 && rfs_set_i && !rfs_code_i[1])
    |=> (cfg_err_o || slave_i));

endmodule

bind audio_clkgen audio_clkgen_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .slave_i(slave_i), .run_i(run_i),
  .rfs_code_i(rfs_code_i), .rfs_set_i(rfs_set_i), .smp_len_i(smp_len_i),
  .rclk_en_o(rclk_en_o), .bclk_en_o(bclk_en_o), .lrclk_o(lrclk_o),
  .cfg_err_o(cfg_err_o)
);

// File: tb/test_audio_clkgen.sv
`timescale 1ns/1ps
module test_audio_clkgen;

  localparam int PRE_W = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic slave, run, pre_en, rfs_set, bfs_set;
  logic [PRE_W-1:0] pre_div;
  logic [1:0] rfs_code, bfs_code, smp_len;
  logic rclk_en, bclk_en, lrclk, cfg_err;

  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  audio_clkgen #(.PRE_W(PRE_W)) i_audio_clkgen (
    .clk_i(clk), .rst_ni(rst_n), .slave_i(slave), .run_i(run),
    .pre_en_i(pre_en), .pre_div_i(pre_div),
    .rfs_code_i(rfs_code), .rfs_set_i(rfs_set),
    .bfs_code_i(bfs_code), .bfs_set_i(bfs_set), .smp_len_i(smp_len),
    .rclk_en_o(rclk_en), .bclk_en_o(bclk_en), .lrclk_o(lrclk), .cfg_err_o(cfg_err)
  );

  // monitor
  logic meas = 1'b0;
  int cyc, n_r, n_b, n_e, bits, orphan, pulses, lr_first;
  int r_t[2], b_t[2], e_t[3];
  logic lr_prev;

  task automatic mon_clear();
    cyc = 0; n_r = 0; n_b = 0; n_e = 0; bits = 0; orphan = 0; pulses = 0;
    lr_first = -1; lr_prev = 1'b0;
  endtask

  always @(negedge clk) if (meas) begin
    if (rclk_en || bclk_en || lrclk) pulses++;
    if (rclk_en) begin if (n_r < 2) r_t[n_r] = cyc; n_r++; end
    if (bclk_en) begin if (n_b < 2) b_t[n_b] = cyc; n_b++; end
    if (bclk_en && !rclk_en) orphan++;
    if (lrclk != lr_prev) begin
      if (n_e < 3) e_t[n_e] = cyc;
      if (n_e == 0) lr_first = int'(lrclk);
      n_e++;
    end
    if ((n_e == 1 || n_e == 2) && bclk_en) bits++;
    lr_prev = lrclk;
    cyc++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int bfs_val(logic [1:0] c);
    case (c) 2'd0: return 32; 2'd1: return 48; 2'd2: return 16; default: return 24; endcase
  endfunction
  function automatic int rfs_val(logic [1:0] c);
    case (c) 2'd0: return 256; 2'd1: return 512; 2'd2: return 384; default: return 768; endcase
  endfunction

  task automatic run_case(input logic sl, input logic en, input int dv,
                          input logic rv, input logic [1:0] rc,
                          input logic bv, input logic [1:0] bc,
                          input logic [1:0] ln);
    int eb, er, p, win;
    bit ee;
    eb = bv ? bfs_val(bc) : (ln == 2'd1 ? 16 : (ln == 2'd2 ? 48 : 32));
    er = rv ? rfs_val(rc) : ((eb == 16 || eb == 32) ? 256 : 384);
    ee = (ln == 2'd3) || (ln == 2'd2 && (er == 256 || er == 512)) || (er % eb != 0);
    p  = en ? dv + 1 : 1;
    @(posedge clk); #1;
    run = 1'b0; slave = sl; pre_en = en; pre_div = PRE_W'(dv);
    rfs_set = rv; rfs_code = rc; bfs_set = bv; bfs_code = bc; smp_len = ln;
    mon_clear(); meas = 1'b1;
    repeat (3) @(posedge clk); #1;
    chk(pulses == 0, "R11 idle quiet", pulses, 0);
    mon_clear();
    run = 1'b1;
    // rewrite settings mid-stream: must be ignored (R11)
    rfs_code = ~rc; bfs_code = bc + 2'd1; smp_len = ln ^ 2'd1;
    pre_en = ~en; pre_div = PRE_W'(dv + 3);
    win = (sl || ee) ? 200 : 2 * er * p + 16;
    repeat (win) @(posedge clk); #1;
    meas = 1'b0; run = 1'b0;
    if (sl) begin
      chk(pulses == 0, "R10 slave quiet", pulses, 0);
      chk(cfg_err == 1'b0, "R10 slave err low", int'(cfg_err), 0);
    end else if (ee) begin
      chk(pulses == 0, "R8/R9 error silent", pulses, 0);
      chk(cfg_err == 1'b1, ln == 2'd2 ? "R8 err flag" : "R9 err flag", int'(cfg_err), 1);
    end else begin
      chk(cfg_err == 1'b0, "R6/R7 no err", int'(cfg_err), 0);
      chk(n_r >= 2 && r_t[1] - r_t[0] == p, en ? "R4 root spacing" : "R5 root spacing",
          r_t[1] - r_t[0], p);
      chk(n_b >= 2 && b_t[1] - b_t[0] == (er / eb) * p, "R1 bit spacing",
          b_t[1] - b_t[0], (er / eb) * p);
      chk(n_e >= 3 && bits == eb, "R2 bits per frame", bits, eb);
      chk(n_e >= 2 && e_t[1] - e_t[0] == (er / 2) * p, "R3 half frame",
          e_t[1] - e_t[0], (er / 2) * p);
      chk(lr_first == 1, "R3 first edge rises", lr_first, 1);
      chk(orphan == 0, "R12 bit without root", orphan, 0);
    end
  endtask

  initial begin
    #800000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5eed_a11d);
    slave = 0; run = 0; pre_en = 0; pre_div = '0;
    rfs_set = 0; rfs_code = 0; bfs_set = 0; bfs_code = 0; smp_len = 0;
    repeat (3) @(posedge clk); #1;
    chk(!rclk_en && !bclk_en && !lrclk && !cfg_err, "R11 reset state",
        int'({rclk_en, bclk_en, lrclk, cfg_err}), 0);
    rst_n = 1'b1;
    // directed corners
    run_case(0, 0, 0, 0, 2'd0, 0, 2'd0, 2'd0);  // R6 R7 16-bit defaults 32/256, R5
    run_case(0, 0, 0, 0, 2'd0, 0, 2'd0, 2'd1);  // R6 8-bit default 16/256
    run_case(0, 1, 1, 0, 2'd0, 0, 2'd0, 2'd2);  // R6 R7 24-bit default 48/384, R4
    run_case(0, 0, 0, 1, 2'd0, 0, 2'd0, 2'd2);  // R8 24-bit with 256
    run_case(0, 0, 0, 1, 2'd1, 1, 2'd3, 2'd2);  // R8 24-bit with 512
    run_case(0, 0, 0, 1, 2'd0, 1, 2'd1, 2'd0);  // R9 256/48
    run_case(0, 0, 0, 0, 2'd0, 0, 2'd0, 2'd3);  // R9 reserved length
    run_case(0, 1, 2, 1, 2'd2, 1, 2'd0, 2'd0);  // R1 384/32
    run_case(0, 0, 0, 1, 2'd3, 1, 2'd2, 2'd0);  // R1 R2 768/16
    run_case(0, 0, 0, 0, 2'd0, 1, 2'd3, 2'd0);  // R7 bit 24 -> root 384
    run_case(1, 0, 0, 1, 2'd0, 1, 2'd1, 2'd2);  // R10 slave, bad settings
    for (int i = 0; i < 22; i++) begin
      run_case(($urandom % 8) == 0, $urandom % 2, $urandom % 3,
               $urandom % 2, 2'($urandom), $urandom % 2, 2'($urandom), 2'($urandom));
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule